// File: doc/BRIEF.md
# Hashed L2 Address Table

This block keeps the learned MAC address table of a switch. Entries live in a bucketed store of four ways per bucket, with a small fully associative overflow store beside it. A bucket is chosen by folding the 60-bit seed, made of the 48-bit MAC above the 12-bit VLAN identifier, into an 11-bit hash with an XOR fold. One input selects between a plain fold and a fold in which three slices are rotated first. The bucket number uses the low `BKT_BITS` bits of that hash.

A host reaches both stores through an indirect command word. It places three 32-bit data words on the write inputs and issues a command that names the store and the slot. The busy flag stays high for a fixed number of cycles. Once it drops, a read result can be taken from the read outputs. A separate lookup port takes a MAC and VLAN and answers one cycle later. The answer gives hit or miss, the stored port, the static flag and whether the hit came from the overflow store.

Top module: `l2_addr_table`

## Requirements
- R1: After reset, busy is 0, the lookup acknowledge is 0, and all three read words are 0. Every slot of both stores then holds all-zero words, so every lookup misses.
- R2: A command is accepted on a clock edge where cmd_wr is 1, cmd_word bit 16 (execute) is 1 and busy is 0. The write words are captured at that edge. Busy is then 1 for exactly CMD_LAT cycles. A command presented while busy is 1 is ignored and changes no slot.
- R3: cmd_word bit 15 selects a read (1) or a write (0), and bits 14:13 select the store. Store code 0 is the bucketed store, with slot index cmd_word[12:0]: the way is in bits 1:0 and the bucket in bits 12:2, of which the low BKT_BITS bits are used. A write stores the three words. A read returns them unchanged on rd_w0..rd_w2 when busy drops, and they hold until the next read completes.
- R4: Store code 1 is the overflow store, with 64 slots addressed by cmd_word[5:0]. It is written and read like store code 0.
- R5: Store codes 2 and 3 complete with the normal busy timing. They change no slot, and a read with them returns three zero words.
- R6: With hash_mode 0, the hash is the XOR of the 11-bit seed slices at bit offsets 0, 11, 22, 33 and 44 and the 9-bit slice at offset 55. The seed is {4'b0, MAC, VID}, with the VID in bits 11:0. The hash appears on lk_hash with the lookup answer.
- R7: With hash_mode 1, three slices are rotated before the same XOR: the slice at 11 is rotated right by 5, the slice at 33 by 6 and the slice at 44 by 7, so that the low bits go to the top.
- R8: An entry matches a lookup only if it is valid and both keys agree. It is valid when any bit of word 0 bits 31:17 is 1. Its VID is in word 0 bits 11:0 and its MAC is {word 1 bits 27:0, word 2 bits 31:12}. On a hit, lk_port is word 0 bits 16:12 and lk_static is word 0 bit 19. The answer (lk_ack high) appears one cycle after lk_req.
- R9: A lookup examines the four ways of its bucket in order 0 to 3 and takes the first match. Only if no way matches does it take the lowest-numbered matching overflow slot, and lk_cam is 1 only in that case.
- R10: On a miss, lk_hit, lk_port, lk_static and lk_cam are all 0.
- R11: A lookup sampled on the same edge where a write completes sees the slot contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_mode | input | 1 | Fold select: 0 plain, 1 rotated |
| cmd_wr | input | 1 | Command word strobe |
| cmd_word | input | 32 | Execute, read, store select, slot index |
| wr_w0 | input | 32 | Write data word 0 |
| wr_w1 | input | 32 | Write data word 1 |
| wr_w2 | input | 32 | Write data word 2 |
| busy | output | 1 | Command in progress |
| rd_w0 | output | 32 | Read data word 0 |
| rd_w1 | output | 32 | Read data word 1 |
| rd_w2 | output | 32 | Read data word 2 |
| lk_req | input | 1 | Lookup request |
| lk_mac | input | 48 | Lookup MAC |
| lk_vid | input | 12 | Lookup VLAN identifier |
| lk_ack | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Valid match found |
| lk_port | output | 5 | Port of matching entry |
| lk_static | output | 1 | Static flag of matching entry |
| lk_cam | output | 1 | Match came from the overflow store |
| lk_hash | output | 11 | Hash of the lookup seed |

## Verification
A host write that completes and a lookup of the same MAC and VLAN can fall on the same clock edge. The bench provokes this by issuing the write and then counting CMD_LAT falling edges, so that the lookup request is sampled exactly at the completing edge. It judges the result by requiring a miss from that lookup and a hit from the one that follows. The reference model answers every lookup from the table state before applying the command that finishes at the same edge, and it is compared with the outputs on every clock.

// File: rtl/l2_tbl_pkg.sv
package l2_tbl_pkg;
  localparam int WORD_W = 32;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int HASH_W = 11;
  localparam int PORT_W = 5;
  localparam int WAYS   = 4;
  localparam int IDX_W  = 13;

  typedef enum logic [1:0] {
    TBL_BUCKET = 2'd0,
    TBL_OVFL   = 2'd1,
    TBL_RSV2   = 2'd2,
    TBL_RSV3   = 2'd3
  } tbl_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] w2;
    logic [WORD_W-1:0] w1;
    logic [WORD_W-1:0] w0;
  } entry_t;
endpackage

// File: rtl/l2_hash_fold.sv
module l2_hash_fold
  import l2_tbl_pkg::*;
(
  input  logic [MAC_W-1:0]  mac,
  input  logic [VID_W-1:0]  vid,
  input  logic              mode,
  output logic [HASH_W-1:0] hash
);
  localparam int SEED_W = 64;
  localparam int NSLICE = 5;

  logic [SEED_W-1:0] seed;
  logic [HASH_W-1:0] slice [NSLICE];
  logic [HASH_W-1:0] fold  [NSLICE];
  logic [8:0]        top_slice;

  assign seed      = {4'b0000, mac, vid};
  assign top_slice = seed[63:55];

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign slice[g] = seed[g*HASH_W +: HASH_W];
  end

  always_comb begin
    fold[0] = slice[0];
    fold[1] = mode ? {slice[1][4:0], slice[1][10:5]} : slice[1];
    fold[2] = slice[2];
    fold[3] = mode ? {slice[3][5:0], slice[3][10:6]} : slice[3];
    fold[4] = mode ? {slice[4][6:0], slice[4][10:7]} : slice[4];
  end

  always_comb begin
    hash = {2'b00, top_slice};
    for (int i = 0; i < NSLICE; i++) hash = hash ^ fold[i];
  end
endmodule

// File: rtl/l2_entry_match.sv
module l2_entry_match
  import l2_tbl_pkg::*;
(
  input  entry_t           ent,
  input  logic [MAC_W-1:0] mac,
  input  logic [VID_W-1:0] vid,
  output logic             hit
);
  logic             live;
  logic [MAC_W-1:0] ent_mac;

  assign live    = |ent.w0[31:17];
  assign ent_mac = {ent.w1[27:0], ent.w2[31:12]};
  assign hit     = live && (ent.w0[VID_W-1:0] == vid) && (ent_mac == mac);
endmodule

// File: rtl/l2_cmd_seq.sv
module l2_cmd_seq
  import l2_tbl_pkg::*;
#(
  parameter int CMD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  input  entry_t            wr_entry,
  output logic              busy,
  output logic              done,
  output logic              op_read,
  output tbl_sel_e          op_tbl,
  output logic [IDX_W-1:0]  op_idx,
  output entry_t            op_entry
);
  localparam int CNT_W = $clog2(CMD_LAT + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign accept = cmd_wr && cmd_word[16] && !busy_q;
  assign done   = busy_q && (cnt_q == CNT_W'(1));
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CMD_LAT);
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_read  <= 1'b0;
      op_tbl   <= TBL_BUCKET;
      op_idx   <= '0;
      op_entry <= '0;
    end else if (accept) begin
      op_read  <= cmd_word[15];
      op_tbl   <= tbl_sel_e'(cmd_word[14:13]);
      op_idx   <= cmd_word[IDX_W-1:0];
      op_entry <= wr_entry;
    end
  end
endmodule

// File: rtl/l2_addr_table.sv
module l2_addr_table
  import l2_tbl_pkg::*;
#(
  parameter int BKT_BITS  = 5,
  parameter int CAM_SLOTS = 64,
  parameter int CMD_LAT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hash_mode,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] wr_w0,
  input  logic [WORD_W-1:0] wr_w1,
  input  logic [WORD_W-1:0] wr_w2,
  output logic              busy,
  output logic [WORD_W-1:0] rd_w0,
  output logic [WORD_W-1:0] rd_w1,
  output logic [WORD_W-1:0] rd_w2,
  input  logic              lk_req,
  input  logic [MAC_W-1:0]  lk_mac,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_ack,
  output logic              lk_hit,
  output logic [PORT_W-1:0] lk_port,
  output logic              lk_static,
  output logic              lk_cam,
  output logic [HASH_W-1:0] lk_hash
);
  localparam int NSRAM   = (1 << BKT_BITS) * WAYS;
  localparam int SRAM_AW = BKT_BITS + 2;
  localparam int CAM_AW  = $clog2(CAM_SLOTS);

  entry_t sram_q [NSRAM];
  entry_t cam_q  [CAM_SLOTS];

  logic             done, op_read;
  tbl_sel_e         op_tbl;
  logic [IDX_W-1:0] op_idx;
  entry_t           op_entry, wr_entry;

  assign wr_entry = '{w2: wr_w2, w1: wr_w1, w0: wr_w0};

  l2_cmd_seq #(.CMD_LAT(CMD_LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_word (cmd_word),
    .wr_entry (wr_entry),
    .busy     (busy),
    .done     (done),
    .op_read  (op_read),
    .op_tbl   (op_tbl),
    .op_idx   (op_idx),
    .op_entry (op_entry)
  );

  logic [SRAM_AW-1:0] sram_addr;
  logic [CAM_AW-1:0]  cam_addr;
  logic               wr_sram, wr_cam, rd_now;
  entry_t             rd_sel, rd_q;

  assign sram_addr = op_idx[SRAM_AW-1:0];
  assign cam_addr  = op_idx[CAM_AW-1:0];
  assign wr_sram   = done && !op_read && (op_tbl == TBL_BUCKET);
  assign wr_cam    = done && !op_read && (op_tbl == TBL_OVFL);
  assign rd_now    = done && op_read;

  always_comb begin
    case (op_tbl)
      TBL_BUCKET: rd_sel = sram_q[sram_addr];
      TBL_OVFL:   rd_sel = cam_q[cam_addr];
      default:    rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRAM; i++) sram_q[i] <= '0;
    end else if (wr_sram) begin
      sram_q[sram_addr] <= op_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAM_SLOTS; i++) cam_q[i] <= '0;
    end else if (wr_cam) begin
      cam_q[cam_addr] <= op_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_now) rd_q <= rd_sel;
  end

  assign rd_w0 = rd_q.w0;
  assign rd_w1 = rd_q.w1;
  assign rd_w2 = rd_q.w2;

  // lookup path
  logic [HASH_W-1:0]   hash_c;
  logic [BKT_BITS-1:0] bucket;
  logic [WAYS-1:0]     way_hit;
  logic [CAM_SLOTS-1:0] cam_hit;
  entry_t              way_ent [WAYS];

  l2_hash_fold u_hash (
    .mac  (lk_mac),
    .vid  (lk_vid),
    .mode (hash_mode),
    .hash (hash_c)
  );

  assign bucket = hash_c[BKT_BITS-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_ent[w] = sram_q[{bucket, 2'(w)}];
    l2_entry_match u_m (
      .ent (way_ent[w]),
      .mac (lk_mac),
      .vid (lk_vid),
      .hit (way_hit[w])
    );
  end

  for (genvar c = 0; c < CAM_SLOTS; c++) begin : g_cam
    l2_entry_match u_m (
      .ent (cam_q[c]),
      .mac (lk_mac),
      .vid (lk_vid),
      .hit (cam_hit[c])
    );
  end

  logic   hit_d, cam_d;
  entry_t win;

  always_comb begin
    hit_d = 1'b0;
    cam_d = 1'b0;
    win   = '0;
    for (int c = CAM_SLOTS - 1; c >= 0; c--) begin
      if (cam_hit[c]) begin
        hit_d = 1'b1;
        cam_d = 1'b1;
        win   = cam_q[c];
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit_d = 1'b1;
        cam_d = 1'b0;
        win   = way_ent[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_ack <= 1'b0;
    else        lk_ack <= lk_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit    <= 1'b0;
      lk_port   <= '0;
      lk_static <= 1'b0;
      lk_cam    <= 1'b0;
      lk_hash   <= '0;
    end else if (lk_req) begin
      lk_hit    <= hit_d;
      lk_port   <= win.w0[16:12];
      lk_static <= win.w0[19];
      lk_cam    <= cam_d;
      lk_hash   <= hash_c;
    end
  end
endmodule

// File: rtl/l2_addr_table_chk.sv
module l2_addr_table_chk #(
  parameter int CMD_LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_word,
  input logic        busy,
  input logic [31:0] rd_w0,
  input logic        lk_req,
  input logic        lk_ack,
  input logic        lk_hit,
  input logic [4:0]  lk_port,
  input logic        lk_cam
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  // R2: busy drops only after exactly CMD_LAT cycles
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (32'(run_q) == CMD_LAT));

  // R2: busy stays high before the latency has elapsed
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (32'(run_q) < CMD_LAT - 1)) |=> busy);

  // R2: an executed command while idle starts a busy period
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_word[16] && !busy) |=> busy);

  // R3: read data only changes when a command completes
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(rd_w0));

  // R8: answer follows request by one cycle
  assert_ack_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_ack);

  assert_no_spurious_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_ack);

  // R10: a miss carries no port and no overflow flag
  assert_miss_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ack && !lk_hit) |-> (lk_port == 5'd0 && !lk_cam));
endmodule

bind l2_addr_table l2_addr_table_chk #(.CMD_LAT(CMD_LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .cmd_word (cmd_word),
  .busy     (busy),
  .rd_w0    (rd_w0),
  .lk_req   (lk_req),
  .lk_ack   (lk_ack),
  .lk_hit   (lk_hit),
  .lk_port  (lk_port),
  .lk_cam   (lk_cam)
);

// File: tb/tb_l2_addr_table.sv
`timescale 1ns/1ps
module tb_l2_addr_table;
  localparam int BKT_BITS = 5;
  localparam int NBKT     = 1 << BKT_BITS;
  localparam int LAT      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hash_mode = 1'b0;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0, wr_w0 = '0, wr_w1 = '0, wr_w2 = '0;
  logic busy;
  logic [31:0] rd_w0, rd_w1, rd_w2;
  logic lk_req = 1'b0;
  logic [47:0] lk_mac = '0;
  logic [11:0] lk_vid = '0;
  logic lk_ack, lk_hit, lk_static, lk_cam;
  logic [4:0] lk_port;
  logic [10:0] lk_hash;

  always #5 clk = ~clk;

  l2_addr_table #(.BKT_BITS(BKT_BITS), .CAM_SLOTS(64), .CMD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode), .cmd_wr(cmd_wr),
    .cmd_word(cmd_word), .wr_w0(wr_w0), .wr_w1(wr_w1), .wr_w2(wr_w2),
    .busy(busy), .rd_w0(rd_w0), .rd_w1(rd_w1), .rd_w2(rd_w2),
    .lk_req(lk_req), .lk_mac(lk_mac), .lk_vid(lk_vid), .lk_ack(lk_ack),
    .lk_hit(lk_hit), .lk_port(lk_port), .lk_static(lk_static),
    .lk_cam(lk_cam), .lk_hash(lk_hash));

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] ref_hash(input logic [47:0] mac, input logic [11:0] vid, input bit mode);
    logic [63:0] s;
    logic [10:0] a, b, c, d, e;
    s = {4'h0, mac, vid};
    a = 11'(s & 64'h7ff);
    b = 11'((s >> 11) & 64'h7ff);
    c = 11'((s >> 22) & 64'h7ff);
    d = 11'((s >> 33) & 64'h7ff);
    e = 11'((s >> 44) & 64'h7ff);
    if (mode) begin
      b = 11'(((b & 11'h1f) << 6) | (b >> 5));
      d = 11'(((d & 11'h3f) << 5) | (d >> 6));
      e = 11'(((e & 11'h7f) << 4) | (e >> 7));
    end
    return a ^ b ^ c ^ d ^ e ^ 11'((s >> 55) & 64'h1ff);
  endfunction

  function automatic logic [95:0] mk(input logic [47:0] mac, input logic [11:0] vid,
                                     input logic [4:0] port, input bit stat, input logic [14:0] vbits);
    logic [31:0] w0, w1, w2;
    w0 = {vbits, 5'd0, vid} | (32'(stat) << 19) | (32'(port) << 12);
    w1 = {4'h0, mac[47:20]};
    w2 = {mac[19:0], 12'h5a5};
    return {w2, w1, w0};
  endfunction

  // reference model
  logic [95:0] m_sram [NBKT*4];
  logic [95:0] m_cam  [64];
  logic [95:0] m_rd, m_opent;
  bit m_busy, m_read, m_ack, m_hit, m_stat, m_camf, m_mode;
  int m_cnt;
  logic [1:0] m_tbl;
  logic [12:0] m_idx;
  logic [4:0] m_port;
  logic [10:0] m_hash;

  function automatic bit ent_match(input logic [95:0] e, input logic [47:0] mac, input logic [11:0] vid);
    return (e[31:17] != 0) && (e[11:0] == vid) && ({e[59:32], e[95:76]} == mac);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBKT*4; i++) m_sram[i] = '0;
      for (int i = 0; i < 64; i++) m_cam[i] = '0;
      m_rd = '0; m_busy = 0; m_cnt = 0; m_ack = 0; m_hit = 0; m_port = 0;
      m_stat = 0; m_camf = 0; m_hash = 0; m_mode = 0;
    end else begin
      m_ack = lk_req;
      if (lk_req) begin
        int b;
        bit found;
        logic [95:0] e;
        m_hash = ref_hash(lk_mac, lk_vid, hash_mode);
        m_mode = hash_mode;
        b = int'(m_hash) % NBKT;
        found = 0; e = '0; m_camf = 0;
        for (int w = 0; w < 4; w++)
          if (!found && ent_match(m_sram[b*4+w], lk_mac, lk_vid)) begin found = 1; e = m_sram[b*4+w]; end
        for (int c = 0; c < 64; c++)
          if (!found && ent_match(m_cam[c], lk_mac, lk_vid)) begin found = 1; e = m_cam[c]; m_camf = 1; end
        m_hit = found; m_port = e[16:12]; m_stat = e[19];
      end
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          int si, ci;
          m_busy = 0;
          si = int'(m_idx) % (NBKT*4);
          ci = int'(m_idx) % 64;
          if (m_read) m_rd = (m_tbl == 0) ? m_sram[si] : (m_tbl == 1) ? m_cam[ci] : '0;
          else if (m_tbl == 0) m_sram[si] = m_opent;
          else if (m_tbl == 1) m_cam[ci] = m_opent;
        end
      end else if (cmd_wr && cmd_word[16]) begin
        m_busy = 1; m_cnt = LAT; m_read = cmd_word[15];
        m_tbl = cmd_word[14:13]; m_idx = cmd_word[12:0];
        m_opent = {wr_w2, wr_w1, wr_w0};
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R2 busy", 96'(busy), 96'(m_busy));
      chk("R3 read words", {rd_w2, rd_w1, rd_w0}, m_rd);
      chk("R8 ack", 96'(lk_ack), 96'(m_ack));
      if (m_ack) begin
        chk("R8 hit", 96'(lk_hit), 96'(m_hit));
        chk("R8 port", 96'(lk_port), 96'(m_port));
        chk("R8 static", 96'(lk_static), 96'(m_stat));
        chk("R9 cam flag", 96'(lk_cam), 96'(m_camf));
        chk(m_mode ? "R7 hash" : "R6 hash", 96'(lk_hash), 96'(m_hash));
      end
    end
  end

  task automatic issue(input bit rd, input logic [1:0] tbl, input logic [12:0] idx, input logic [95:0] ent);
    @(negedge clk);
    cmd_wr = 1; cmd_word = {15'd0, 1'b1, rd, tbl, idx};
    {wr_w2, wr_w1, wr_w0} = ent;
    @(negedge clk);
    cmd_wr = 0; cmd_word = '0;
  endtask

  task automatic host(input bit rd, input logic [1:0] tbl, input logic [12:0] idx, input logic [95:0] ent);
    issue(rd, tbl, idx, ent);
    while (busy) @(negedge clk);
  endtask

  task automatic look(input logic [47:0] mac, input logic [11:0] vid);
    @(negedge clk);
    lk_req = 1; lk_mac = mac; lk_vid = vid;
    @(negedge clk);
    lk_req = 0;
  endtask

  function automatic logic [12:0] sidx(input logic [47:0] mac, input logic [11:0] vid, input bit mode, input int way);
    return 13'((int'(ref_hash(mac, vid, mode)) % NBKT) * 4 + way);
  endfunction

  task automatic finish_run();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    finish_run();
  end

  localparam logic [47:0] MA = 48'h0123_4567_89ab;
  localparam logic [11:0] VA = 12'h00a;
  localparam logic [47:0] MP = 48'hfeed_0bad_c0de;
  localparam logic [11:0] VP = 12'h321;

  initial begin
    logic [95:0] ea, e1, e2;
    int run;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", 96'(busy), 96'd0);
    chk("R1 read words after reset", {rd_w2, rd_w1, rd_w0}, 96'd0);
    chk("R1 ack after reset", 96'(lk_ack), 96'd0);
    look(MA, VA);
    chk("R1 empty table misses", 96'(lk_hit), 96'd0);

    // R3 bucket write and read back
    ea = mk(MA, VA, 5'd7, 1'b0, 15'h0001);
    host(0, 2'd0, sidx(MA, VA, 0, 2), ea);
    host(1, 2'd0, sidx(MA, VA, 0, 2), '0);
    chk("R3 bucket readback", {rd_w2, rd_w1, rd_w0}, ea);
    look(MA, VA);
    chk("R8 hit port", {lk_hit, lk_cam, lk_port}, {1'b1, 1'b0, 5'd7});
    chk("R6 hash value", 96'(lk_hash), 96'(ref_hash(MA, VA, 0)));
    hash_mode = 1;
    look(MA, VA);
    chk("R7 hash value", 96'(lk_hash), 96'(ref_hash(MA, VA, 1)));
    look(MP, VP);
    chk("R7 second seed", 96'(lk_hash), 96'(ref_hash(MP, VP, 1)));
    hash_mode = 0;

    // R4 overflow store
    e1 = mk(48'h1111_2222_3333, 12'h044, 5'd12, 1'b1, 15'h0000);
    host(0, 2'd1, 13'd40, e1);
    host(1, 2'd1, 13'd40, '0);
    chk("R4 overflow readback", {rd_w2, rd_w1, rd_w0}, e1);
    look(48'h1111_2222_3333, 12'h044);
    chk("R4 overflow hit", {lk_hit, lk_cam, lk_static, lk_port}, {3'b111, 5'd12});

    // R9 priority: way0, way3, overflow slots 5 and 2
    host(0, 2'd0, sidx(MP, VP, 0, 3), mk(MP, VP, 5'd9, 0, 15'h4000));
    host(0, 2'd0, sidx(MP, VP, 0, 0), mk(MP, VP, 5'd3, 0, 15'h0001));
    host(0, 2'd1, 13'd5, mk(MP, VP, 5'd20, 0, 15'h0001));
    look(MP, VP);
    chk("R9 way0 first", {lk_hit, lk_cam, lk_port}, {2'b10, 5'd3});
    host(0, 2'd0, sidx(MP, VP, 0, 0), mk(MP, VP, 5'd3, 0, 15'h0000));
    look(MP, VP);
    chk("R8 invalid way skipped", {lk_hit, lk_cam, lk_port}, {2'b10, 5'd9});
    host(0, 2'd0, sidx(MP, VP, 0, 3), mk(MP, VP, 5'd9, 0, 15'h0000));
    look(MP, VP);
    chk("R9 overflow fallback", {lk_hit, lk_cam, lk_port}, {2'b11, 5'd20});
    host(0, 2'd1, 13'd2, mk(MP, VP, 5'd21, 0, 15'h0100));
    look(MP, VP);
    chk("R9 lowest overflow slot", {lk_hit, lk_cam, lk_port}, {2'b11, 5'd21});

    // R10 miss
    look(MP, VP + 12'd1);
    chk("R10 miss outputs", {lk_hit, lk_cam, lk_static, lk_port}, 8'd0);

    // R5 reserved store codes
    host(0, 2'd2, sidx(MA, VA, 0, 2), mk(MA, VA, 5'd1, 0, 15'h0001));
    host(1, 2'd0, sidx(MA, VA, 0, 2), '0);
    chk("R5 reserved write no effect", {rd_w2, rd_w1, rd_w0}, ea);
    host(1, 2'd3, sidx(MA, VA, 0, 2), '0);
    chk("R5 reserved read zero", {rd_w2, rd_w1, rd_w0}, 96'd0);

    // R2 busy length and ignored command
    e1 = mk(48'h0a0b_0c0d_0e0f, 12'h077, 5'd4, 0, 15'h0001);
    e2 = mk(48'h0a0b_0c0d_0e0f, 12'h077, 5'd30, 0, 15'h0001);
    issue(0, 2'd1, 13'd60, e1);
    run = 1;
    cmd_wr = 1; cmd_word = {15'd0, 1'b1, 1'b0, 2'd1, 13'd60};
    {wr_w2, wr_w1, wr_w0} = e2;
    @(negedge clk);
    cmd_wr = 0; cmd_word = '0;
    while (busy) begin run++; @(negedge clk); end
    chk("R2 busy cycles", 96'(run), 96'(LAT));
    host(1, 2'd1, 13'd60, '0);
    chk("R2 command while busy ignored", {rd_w2, rd_w1, rd_w0}, e1);

    // R11 lookup on the completing edge
    e1 = mk(48'hc0c0_a1a1_b2b2, 12'h0ee, 5'd17, 0, 15'h0001);
    @(negedge clk);
    cmd_wr = 1; cmd_word = {15'd0, 1'b1, 1'b0, 2'd0, sidx(48'hc0c0_a1a1_b2b2, 12'h0ee, 0, 1)};
    {wr_w2, wr_w1, wr_w0} = e1;
    @(negedge clk);
    cmd_wr = 0; cmd_word = '0;
    repeat (LAT - 1) @(negedge clk);
    lk_req = 1; lk_mac = 48'hc0c0_a1a1_b2b2; lk_vid = 12'h0ee;
    @(negedge clk);
    lk_req = 0;
    chk("R11 same-edge lookup sees old contents", {busy, lk_ack, lk_hit}, 3'b010);
    look(48'hc0c0_a1a1_b2b2, 12'h0ee);
    chk("R11 next lookup sees write", {lk_hit, lk_port}, {1'b1, 5'd17});

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule